// File: doc/BRIEF.md
# ADC Conversion-Group Result Buffer

This block holds the results of one group of analog-to-digital conversions and decides when that group starts. An external converter interface hands it 12-bit results, each tagged with a 5-bit input channel number. The block stores them in order in a small memory. Software reads them back in one of two ways. The queue port returns the oldest unread result and advances on each read. The direct port reads any location by address.

A channel-select register starts the group. In software-trigger mode, any non-zero write starts a conversion. In hardware-trigger mode, the block waits for a single-cycle trigger pulse while the register holds a non-zero value. A non-zero write also empties the memory, except when the keep-results control is set and the group is idle. When the memory fills up, a control bit picks between two responses. In stall mode, new results are refused until every stored result has been read. In wrap mode, writing resumes at the first location. Queue-port reads can shorten the result to 10 or 8 bits and can tag it with the channel number.

Top module: `adc_grp_resbuf`

## Requirements
- R1: After reset the group is idle, no start pulse is present, the channel-select value is zero, the queue is empty and reads zero, and the overrun flag is clear.
- R2: In software-trigger mode (`cfg_hw_trig` = 0), a write of a non-zero value to the channel-select register produces a one-cycle `grp_start` pulse and sets `grp_active` in the cycle after the write. A write of zero starts nothing.
- R3: In hardware-trigger mode (`cfg_hw_trig` = 1), channel-select writes start nothing. A `hw_trig` pulse starts the group only when the stored channel-select value is non-zero and the group is idle. A trigger that arrives while the group is active is ignored.
- R4: `grp_active` clears after a result arrives with `cnv_last` set.
- R5: A non-zero channel-select write clears the memory: the queue becomes empty and every location reads zero on the direct port. The exception is when `cfg_keep_on_sel` is 1 and the group is idle; the memory is then left as it was. While the group is active, a non-zero write always clears. A write of zero never clears.
- R6: Results are stored in arrival order, starting at location 0. A direct-port read at `ram_addr` returns the channel number in bits 16..12 and the 12-bit result in bits 11..0, whatever `cfg_id_en` is set to.
- R7: Each `fifo_rd` pulse advances the queue by one entry, so reads return results oldest first. A read of an empty queue returns zero and leaves the read position unchanged.
- R8: The queue-port word depends on `cfg_fmt`. Values 0 and 3 return the 12-bit result in bits 11..0. Value 1 returns result bits 11..2 in bits 9..0. Value 2 returns result bits 11..4 in bits 7..0. All bits not named here read zero.
- R9: With `cfg_id_en` = 1 and `cfg_fmt` set to 1 or 2, queue-port bits 14..10 carry the channel number; with `cfg_id_en` = 0 those bits read zero. In formats 0 and 3 the channel number is never inserted.
- R10: In stall mode (`cfg_wrap` = 0), a result that arrives while all DEPTH locations hold data is dropped. Results stay refused until all DEPTH entries have been read. The next result after that is stored at location 0.
- R11: In wrap mode (`cfg_wrap` = 1), a result that arrives while the memory is full is written at location 0. Older unread results are discarded, so the queue then holds only the new result.
- R12: `ovr_flag` sets when a result arrives while the memory is full, in either mode. It stays set until an `ovr_clr` pulse clears it. If a new overrun and `ovr_clr` happen in the same cycle, the flag stays set.
- R13: If a result arrives in the same cycle as a clearing channel-select write, the clear wins and the result is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hw_trig | input | 1 | 1 selects hardware-trigger mode |
| cfg_keep_on_sel | input | 1 | 1 keeps results on a channel-select write while the group is idle |
| cfg_wrap | input | 1 | 1 selects wrap-overwrite on overrun; 0 selects stall |
| cfg_fmt | input | 2 | Queue-port read format |
| cfg_id_en | input | 1 | Insert the channel number into queue-port words |
| sel_we | input | 1 | Channel-select register write strobe |
| sel_wdata | input | SEL_W | Channel-select write value |
| hw_trig | input | 1 | Hardware trigger, single-cycle pulse |
| cnv_valid | input | 1 | A conversion result is present |
| cnv_last | input | 1 | This result ends the group |
| cnv_res | input | 12 | Conversion result |
| cnv_chid | input | 5 | Channel number of the result |
| fifo_rd | input | 1 | Queue-port read strobe |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| ram_addr | input | AW | Direct-port address |
| grp_sel | output | SEL_W | Current channel-select value |
| grp_start | output | 1 | One-cycle group start pulse to the converter |
| grp_active | output | 1 | Group conversion in progress |
| fifo_rdata | output | 16 | Queue-port word at the head of the queue |
| fifo_empty | output | 1 | No unread results |
| ram_rdata | output | 17 | Direct-port word at `ram_addr` |
| ovr_flag | output | 1 | Overrun status |

## Verification
The bench fills the memory to exactly DEPTH entries and then sends more results, in both overrun modes. A design with an off-by-one full test, or one that resumes stall-mode writes after a single read, would return dropped results out of order or leave the restart result somewhere other than location 0. It sweeps every combination of read format and channel-number enable against arithmetic expectations. A wrong bit slice would show up as a shifted value or a stray channel number in format 0. It runs the keep-results rule both while the group is active and while it is idle. A design that ignored the active state would keep stale data, and one that ignored the keep bit would empty the memory without need. Triggers that are refused must not start the group: one with a zero channel select, one while the group is active, and one from a write in hardware mode. A design that started on any of them would show a spurious start pulse.

// File: rtl/adc_grp_pkg.sv
package adc_grp_pkg;
    localparam int RES_W  = 12;
    localparam int ID_W   = 5;
    localparam int FIFO_W = 16;
    localparam int RAM_W  = ID_W + RES_W;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [RES_W-1:0] res;
    } res_entry_t;

    typedef enum logic [1:0] {
        FMT_FULL  = 2'd0,
        FMT_TEN   = 2'd1,
        FMT_EIGHT = 2'd2,
        FMT_RSVD  = 2'd3
    } rd_fmt_e;
endpackage

// File: rtl/grp_trig_ctrl.sv
module grp_trig_ctrl #(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             cfg_hw_trig,
    input  logic             cfg_keep_on_sel,
    input  logic             hw_trig,
    input  logic             done_evt,
    output logic [SEL_W-1:0] sel_val,
    output logic             active,
    output logic             start,
    output logic             clr_ram
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             active;
        logic             start;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic     nz_write;
    logic     start_c;

    always_comb begin
        nz_write = sel_we && (|sel_wdata);
        clr_ram  = nz_write && (!cfg_keep_on_sel || st_q.active);
        if (cfg_hw_trig) begin
            start_c = hw_trig && (|st_q.sel) && !st_q.active;
        end else begin
            start_c = nz_write;
        end

        st_d       = st_q;
        st_d.start = start_c;
        if (sel_we) begin
            st_d.sel = sel_wdata;
        end
        if (start_c) begin
            st_d.active = 1'b1;
        end else if (done_evt) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_val = st_q.sel;
    assign active  = st_q.active;
    assign start   = st_q.start;
endmodule

// File: rtl/grp_res_store.sv
module grp_res_store
    import adc_grp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  res_entry_t    wr_entry,
    input  logic          rd_en,
    input  logic          cfg_wrap,
    input  logic          ovr_clr,
    input  logic [AW-1:0] raddr,
    output res_entry_t    head,
    output logic          empty,
    output logic          ovr,
    output res_entry_t    dir_entry
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] ONE      = PW'(1);

    typedef struct packed {
        res_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic                   ovr;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      full;
    logic      is_empty;

    always_comb begin
        full     = (st_q.wp == FULL_CNT);
        is_empty = (st_q.rp == st_q.wp);
        st_d     = st_q;

        if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end

        if (clr) begin
            st_d.mem = '0;
            st_d.wp  = '0;
            st_d.rp  = '0;
        end else begin
            if (rd_en && !is_empty) begin
                st_d.rp = st_q.rp + ONE;
            end
            if (wr_en) begin
                if (!full) begin
                    st_d.mem[st_q.wp[AW-1:0]] = wr_entry;
                    st_d.wp = st_q.wp + ONE;
                end else begin
                    st_d.ovr = 1'b1;
                    if (cfg_wrap) begin
                        st_d.mem[0] = wr_entry;
                        st_d.wp     = ONE;
                        st_d.rp     = '0;
                    end
                end
            end
            if ((st_d.wp == FULL_CNT) && (st_d.rp == FULL_CNT)) begin
                st_d.wp = '0;
                st_d.rp = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rp[AW-1:0]];
    assign empty     = is_empty;
    assign ovr       = st_q.ovr;
    assign dir_entry = st_q.mem[raddr];
endmodule

// File: rtl/grp_rd_fmt.sv
module grp_rd_fmt
    import adc_grp_pkg::*;
(
    input  res_entry_t        entry,
    input  logic              empty,
    input  logic [1:0]        fmt,
    input  logic              id_en,
    output logic [FIFO_W-1:0] word
);
    logic [ID_W-1:0] id_fld;

    always_comb begin
        id_fld = id_en ? entry.id : '0;
        if (empty) begin
            word = '0;
        end else begin
            case (rd_fmt_e'(fmt))
                FMT_TEN:   word = {1'b0, id_fld, entry.res[RES_W-1:2]};
                FMT_EIGHT: word = {1'b0, id_fld, 2'b00, entry.res[RES_W-1:4]};
                default:   word = {{(FIFO_W-RES_W){1'b0}}, entry.res};
            endcase
        end
    end
endmodule

// File: rtl/adc_grp_resbuf.sv
module adc_grp_resbuf
    import adc_grp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEL_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hw_trig,
    input  logic              cfg_keep_on_sel,
    input  logic              cfg_wrap,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_id_en,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              hw_trig,
    input  logic              cnv_valid,
    input  logic              cnv_last,
    input  logic [RES_W-1:0]  cnv_res,
    input  logic [ID_W-1:0]   cnv_chid,
    input  logic              fifo_rd,
    input  logic              ovr_clr,
    input  logic [AW-1:0]     ram_addr,
    output logic [SEL_W-1:0]  grp_sel,
    output logic              grp_start,
    output logic              grp_active,
    output logic [FIFO_W-1:0] fifo_rdata,
    output logic              fifo_empty,
    output logic [RAM_W-1:0]  ram_rdata,
    output logic              ovr_flag
);
    logic       clr_ram;
    res_entry_t wr_entry;
    res_entry_t head;
    res_entry_t dir_entry;

    assign wr_entry = '{id: cnv_chid, res: cnv_res};

    grp_trig_ctrl #(.SEL_W(SEL_W)) u_trig (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_we          (sel_we),
        .sel_wdata       (sel_wdata),
        .cfg_hw_trig     (cfg_hw_trig),
        .cfg_keep_on_sel (cfg_keep_on_sel),
        .hw_trig         (hw_trig),
        .done_evt        (cnv_valid && cnv_last),
        .sel_val         (grp_sel),
        .active          (grp_active),
        .start           (grp_start),
        .clr_ram         (clr_ram)
    );

    grp_res_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_ram),
        .wr_en     (cnv_valid),
        .wr_entry  (wr_entry),
        .rd_en     (fifo_rd),
        .cfg_wrap  (cfg_wrap),
        .ovr_clr   (ovr_clr),
        .raddr     (ram_addr),
        .head      (head),
        .empty     (fifo_empty),
        .ovr       (ovr_flag),
        .dir_entry (dir_entry)
    );

    grp_rd_fmt u_fmt (
        .entry (head),
        .empty (fifo_empty),
        .fmt   (cfg_fmt),
        .id_en (cfg_id_en),
        .word  (fifo_rdata)
    );

    assign ram_rdata = dir_entry;
endmodule

// File: rtl/adc_grp_resbuf_chk.sv
module adc_grp_resbuf_chk #(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_hw_trig,
    input logic             cfg_keep_on_sel,
    input logic [1:0]       cfg_fmt,
    input logic             cfg_id_en,
    input logic             sel_we,
    input logic [SEL_W-1:0] sel_wdata,
    input logic             hw_trig,
    input logic             cnv_valid,
    input logic             cnv_last,
    input logic             ovr_clr,
    input logic             grp_start,
    input logic             grp_active,
    input logic [15:0]      fifo_rdata,
    input logic             fifo_empty,
    input logic             ovr_flag
);
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        grp_start |-> grp_active); // R2

    AST_HW_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_trig && !hw_trig) |=> !grp_start); // R3

    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_active) |-> $past(cnv_valid && cnv_last)); // R4

    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && (|sel_wdata) && (!cfg_keep_on_sel || grp_active)) |=> fifo_empty); // R5

    AST_FMT8_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt == 2'd2 && !cfg_id_en) |-> (fifo_rdata[15:8] == 8'h00)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag); // R12
endmodule

bind adc_grp_resbuf adc_grp_resbuf_chk #(.SEL_W(SEL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_hw_trig     (cfg_hw_trig),
    .cfg_keep_on_sel (cfg_keep_on_sel),
    .cfg_fmt         (cfg_fmt),
    .cfg_id_en       (cfg_id_en),
    .sel_we          (sel_we),
    .sel_wdata       (sel_wdata),
    .hw_trig         (hw_trig),
    .cnv_valid       (cnv_valid),
    .cnv_last        (cnv_last),
    .ovr_clr         (ovr_clr),
    .grp_start       (grp_start),
    .grp_active      (grp_active),
    .fifo_rdata      (fifo_rdata),
    .fifo_empty      (fifo_empty),
    .ovr_flag        (ovr_flag)
);

// File: tb/adc_grp_resbuf_bench.sv
module adc_grp_resbuf_bench;
    localparam int DEPTH = 16;
    localparam int SEL_W = 16;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_hw_trig = 1'b0, cfg_keep_on_sel = 1'b0, cfg_wrap = 1'b0;
    logic [1:0]       cfg_fmt = 2'd0;
    logic             cfg_id_en = 1'b0;
    logic             sel_we = 1'b0;
    logic [SEL_W-1:0] sel_wdata = '0;
    logic             hw_trig = 1'b0, cnv_valid = 1'b0, cnv_last = 1'b0;
    logic [11:0]      cnv_res = '0;
    logic [4:0]       cnv_chid = '0;
    logic             fifo_rd = 1'b0, ovr_clr = 1'b0;
    logic [AW-1:0]    ram_addr = '0;
    logic [SEL_W-1:0] grp_sel;
    logic             grp_start, grp_active, fifo_empty, ovr_flag;
    logic [15:0]      fifo_rdata;
    logic [16:0]      ram_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_grp_resbuf #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_adc_grp_resbuf (
        .clk(clk), .rst_n(rst_n), .cfg_hw_trig(cfg_hw_trig), .cfg_keep_on_sel(cfg_keep_on_sel),
        .cfg_wrap(cfg_wrap), .cfg_fmt(cfg_fmt), .cfg_id_en(cfg_id_en), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .hw_trig(hw_trig), .cnv_valid(cnv_valid), .cnv_last(cnv_last),
        .cnv_res(cnv_res), .cnv_chid(cnv_chid), .fifo_rd(fifo_rd), .ovr_clr(ovr_clr),
        .ram_addr(ram_addr), .grp_sel(grp_sel), .grp_start(grp_start), .grp_active(grp_active),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .ram_rdata(ram_rdata), .ovr_flag(ovr_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] r, input logic [4:0] id, input logic last);
        cnv_valid = 1'b1; cnv_res = r; cnv_chid = id; cnv_last = last;
        tick();
        cnv_valid = 1'b0; cnv_last = 1'b0;
    endtask

    task automatic wsel(input logic [SEL_W-1:0] v);
        sel_we = 1'b1; sel_wdata = v;
        tick();
        sel_we = 1'b0;
    endtask

    task automatic pop(output logic [15:0] v);
        v = fifo_rdata;
        fifo_rd = 1'b1;
        tick();
        fifo_rd = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [16:0] v);
        ram_addr = a;
        #0.5;
        v = ram_rdata;
    endtask

    function automatic logic [15:0] exp_fifo(input logic [11:0] r, input logic [4:0] id,
                                             input int f, input logic ie);
        logic [15:0] idw;
        idw = ie ? (16'(id) << 10) : 16'h0;
        if (f == 1) return 16'(r >> 2) | idw;
        if (f == 2) return 16'(r >> 4) | idw;
        return 16'(r);
    endfunction

    function automatic logic [11:0] rv(input int i, input int k, input int c);
        return 12'((i * k + c) % 4096);
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [16:0] d;

        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 active", grp_active, 0);
        chk("R1 start", grp_start, 0);
        chk("R1 sel", grp_sel, 0);
        chk("R1 empty", fifo_empty, 1);
        chk("R1 rdata", fifo_rdata, 0);
        chk("R1 ovr", ovr_flag, 0);

        // R2 software trigger
        wsel(0);
        chk("R2 zero write no start", grp_start, 0);
        wsel(16'h0003);
        chk("R2 start pulse", grp_start, 1);
        chk("R2 active", grp_active, 1);
        tick();
        chk("R2 start one cycle", grp_start, 0);

        // R6 R4 store five results
        for (int i = 0; i < 5; i++) push(rv(i, 613, 17), 5'(i + 3), i == 4);
        chk("R4 active cleared", grp_active, 0);
        for (int i = 0; i < 5; i++) begin
            peek(AW'(i), d);
            chk("R6 direct word", d, {5'(i + 3), rv(i, 613, 17)});
        end
        cfg_id_en = 1'b1;
        peek(0, d);
        chk("R6 direct ignores id enable", d, {5'd3, rv(0, 613, 17)});

        // R8 R9 format sweep on head entry
        for (int f = 0; f < 4; f++) begin
            for (int e = 0; e < 2; e++) begin
                cfg_fmt = 2'(f); cfg_id_en = e[0];
                #0.5;
                chk("R8 R9 format", fifo_rdata, exp_fifo(rv(0, 613, 17), 5'd3, f, e[0]));
            end
        end
        cfg_fmt = 2'd0; cfg_id_en = 1'b0;

        // R7 ordered reads and empty read
        for (int i = 0; i < 5; i++) begin
            pop(w);
            chk("R7 order", w, 16'(rv(i, 613, 17)));
        end
        chk("R7 empty", fifo_empty, 1);
        pop(w);
        chk("R7 empty read zero", w, 0);
        push(12'habc, 5'd7, 1'b0);
        chk("R7 pointer held", fifo_rdata, 16'h0abc);
        pop(w);

        // R5 keep bit while idle, clear while active
        push(12'h5a5, 5'd9, 1'b0);
        cfg_keep_on_sel = 1'b1;
        wsel(16'h0005);
        chk("R5 keep idle not empty", fifo_empty, 0);
        peek(6, d);
        chk("R5 keep idle content", d, {5'd9, 12'h5a5});
        chk("R5 started", grp_active, 1);
        wsel(16'h0006);
        chk("R5 active clears", fifo_empty, 1);
        peek(6, d);
        chk("R5 cleared content", d, 0);
        cfg_keep_on_sel = 1'b0;
        push(12'h111, 5'd1, 1'b1);
        wsel(0);
        chk("R5 zero write keeps", fifo_empty, 0);
        wsel(16'h0004);
        chk("R5 idle clear without keep", fifo_empty, 1);
        push(12'h0, 5'd0, 1'b1);

        // R3 hardware trigger
        cfg_hw_trig = 1'b1;
        wsel(0);
        chk("R3 write no start", grp_start, 0);
        hw_trig = 1'b1; tick(); hw_trig = 1'b0;
        chk("R3 zero select trig", grp_start, 0);
        wsel(16'h0009);
        chk("R3 hw write no start", grp_start, 0);
        hw_trig = 1'b1; tick(); hw_trig = 1'b0;
        chk("R3 trig start", grp_start, 1);
        chk("R3 active", grp_active, 1);
        tick();
        hw_trig = 1'b1; tick(); hw_trig = 1'b0;
        chk("R3 trig while active", grp_start, 0);
        push(12'h0, 5'd0, 1'b1);

        // R10 stall overrun
        wsel(16'h000a);
        for (int i = 0; i < DEPTH; i++) push(rv(i, 97, 5), 5'(i), 1'b0);
        chk("R12 no ovr at full", ovr_flag, 0);
        push(12'hfff, 5'd31, 1'b0);
        chk("R12 ovr set", ovr_flag, 1);
        pop(w);
        chk("R10 first", w, 16'(rv(0, 97, 5)));
        push(12'heee, 5'd30, 1'b0);
        for (int i = 1; i < DEPTH; i++) begin
            pop(w);
            chk("R10 drop order", w, 16'(rv(i, 97, 5)));
        end
        chk("R10 drained", fifo_empty, 1);
        push(12'h321, 5'd12, 1'b0);
        peek(0, d);
        chk("R10 restart at 0", d, {5'd12, 12'h321});
        chk("R10 head", fifo_rdata, 16'h0321);
        pop(w);
        chk("R12 ovr held", ovr_flag, 1);
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        chk("R12 ovr cleared", ovr_flag, 0);

        // R11 wrap overrun, R12 set wins over clear
        cfg_wrap = 1'b1;
        wsel(16'h000b);
        for (int i = 0; i < DEPTH; i++) push(rv(i, 131, 9), 5'(i), 1'b0);
        ovr_clr = 1'b1;
        push(12'hfed, 5'd31, 1'b0);
        ovr_clr = 1'b0;
        chk("R12 set wins", ovr_flag, 1);
        chk("R11 head new", fifo_rdata, 16'h0fed);
        peek(0, d);
        chk("R11 loc0", d, {5'd31, 12'hfed});
        peek(1, d);
        chk("R11 loc1 old", d, {5'd1, rv(1, 131, 9)});
        pop(w);
        chk("R11 only one", fifo_empty, 1);

        // R13 clear beats result
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        cnv_valid = 1'b1; cnv_res = 12'h777; cnv_chid = 5'd2;
        sel_we = 1'b1; sel_wdata = 16'h000c;
        tick();
        cnv_valid = 1'b0; sel_we = 1'b0;
        chk("R13 empty", fifo_empty, 1);
        peek(2, d);
        chk("R13 discarded", d, 0);
        chk("R13 no ovr", ovr_flag, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule